// File: doc/BRIEF.md
# Receive Line Idle Time-out Counter

This block watches a serial receiver for silence once traffic has started. A programmable window, counted in bit periods, is loaded each time a character is received. The window shrinks by one on every bit-period tick. When it runs out, a sticky time-out flag is raised. The count does not start at reset. It also does not start after a restart command. In both cases it waits for a first character, so a line that has never carried traffic is never reported as idle. A window value of zero turns detection off.

The block has no data stream, so no valid/ready handshake is involved. Its single-cycle event pulses (`char_done`, `bit_tick`, `to_restart`) are accepted in every cycle and cannot be back-pressured. The window value is a plain level input. The flag is a plain registered status output.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset `to_flag` is 0 and the counter is disarmed.
- R2: While `to_value` is 0, `to_flag` never rises, and the block drops back to the disarmed state.
- R3: While disarmed, `bit_tick` pulses have no effect; `to_flag` stays 0 whatever the number of ticks.
- R4: A `char_done` with a non-zero `to_value` arms the counter with that value. Each later `bit_tick` lowers it by one. `to_flag` becomes 1 in the cycle after the clock edge that samples the `to_value`-th tick, which is the edge where the count reaches zero. Counting then stops without wrapping.
- R5: While armed, every `char_done` reloads the window with `to_value`. When `char_done` and `bit_tick` fall in the same cycle, the reload wins and the tick is dropped.
- R6: `to_flag` is sticky. Once set, it stays 1 through any ticks, characters or changes of `to_value` until a restart. Characters do not re-arm the counter while the flag is set.
- R7: A `to_restart` pulse clears `to_flag` at the next edge and disarms the counter. A `char_done` in the same cycle as `to_restart` is ignored. Counting resumes only after a later character.
- R8: The window covers the full `TO_W`-bit range: with `to_value` = 255 (TO_W = 8), the flag rises on the 255th tick after the arming character and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| to_value | input | TO_W | Time-out window in bit periods; 0 disables detection |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_done | input | 1 | One-cycle pulse per received character |
| to_restart | input | 1 | One-cycle command: clear flag and wait for a first character |
| to_flag | output | 1 | Sticky idle time-out flag |

## Verification
The bench builds the block with the default TO_W of 8. At that width the largest window, 255 ticks, takes only a few hundred cycles, so the R8 corner is exercised as a directed case rather than reached by scaling a parameter. Random traffic is drawn mostly with windows of 1 to 5 ticks and occasional zeros. This makes expiry, reload-versus-tick collisions, restarts during a count and a window turning zero in mid-count all frequent within a few thousand cycles.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rxto_state_e;
endpackage

// File: rtl/rxto_count.sv
module rxto_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         cnt_last
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - ONE;
  end

  assign cnt_last = (cnt == ONE);
endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
  import rxto_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        cfg_zero,
  input  logic        char_done,
  input  logic        bit_tick,
  input  logic        cnt_last,
  output rxto_state_e state,
  output logic        load,
  output logic        dec,
  output logic        flag
);
  rxto_state_e nxt;

  always_comb begin
    nxt  = state;
    load = 1'b0;
    dec  = 1'b0;
    if (restart) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!cfg_zero && char_done) begin
            nxt  = ST_RUN;
            load = 1'b1;
          end
        end
        ST_RUN: begin
          if (cfg_zero) begin
            nxt = ST_IDLE;
          end else if (char_done) begin
            load = 1'b1;
          end else if (bit_tick) begin
            dec = 1'b1;
            if (cnt_last) nxt = ST_DONE;
          end
        end
        default: nxt = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      flag  <= 1'b0;
    end else begin
      state <= nxt;
      flag  <= (nxt == ST_DONE);
    end
  end
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rxto_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TO_W-1:0] to_value,
  input  logic            bit_tick,
  input  logic            char_done,
  input  logic            to_restart,
  output logic            to_flag
);
  rxto_state_e     state_q;
  logic            load, dec, cnt_last;
  logic [TO_W-1:0] cnt_q;
  logic            cfg_zero;

  assign cfg_zero = (to_value == '0);

  rxto_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (to_restart),
    .cfg_zero  (cfg_zero),
    .char_done (char_done),
    .bit_tick  (bit_tick),
    .cnt_last  (cnt_last),
    .state     (state_q),
    .load      (load),
    .dec       (dec),
    .flag      (to_flag)
  );

  rxto_count #(.W(TO_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .dec      (dec),
    .load_val (to_value),
    .cnt      (cnt_q),
    .cnt_last (cnt_last)
  );
endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk #(
  parameter int TO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TO_W-1:0] to_value,
  input logic            bit_tick,
  input logic            char_done,
  input logic            to_restart,
  input logic            to_flag,
  input logic [TO_W-1:0] cnt,
  input logic [1:0]      state
);
  a_r2_zero_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (to_value == '0 && !to_flag) |=> !to_flag);

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && !char_done) |=> (state == 2'd0 && !to_flag));

  a_r4_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !to_flag) |=> !to_flag);

  a_r4_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag |-> cnt == '0);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && char_done && !to_restart && to_value != '0)
      |=> cnt == $past(to_value));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && !to_restart) |=> to_flag);

  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    to_restart |=> (!to_flag && state == 2'd0));
endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.TO_W(TO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .to_value   (to_value),
  .bit_tick   (bit_tick),
  .char_done  (char_done),
  .to_restart (to_restart),
  .to_flag    (to_flag),
  .cnt        (cnt_q),
  .state      (state_q)
);

// File: tb/rx_idle_timeout_test.sv
`timescale 1ns/1ps
module rx_idle_timeout_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] to_value = '0;
  logic       bit_tick = 1'b0;
  logic       char_done = 1'b0;
  logic       to_restart = 1'b0;
  logic       to_flag;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // model: 0 disarmed, 1 counting, 2 expired
  int m_st  = 0;
  int m_cnt = 0;
  bit m_flag = 0;

  always #2 clk = ~clk;

  rx_idle_timeout #(.TO_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .to_value(to_value), .bit_tick(bit_tick),
    .char_done(char_done), .to_restart(to_restart), .to_flag(to_flag)
  );

  function automatic int next_st(int st, int cnt, bit c, bit t, bit r, int v);
    if (r) return 0;
    if (st == 2) return 2;
    if (v == 0) return 0;
    if (st == 0) return c ? 1 : 0;
    if (c) return 1;
    if (t && cnt == 1) return 2;
    return 1;
  endfunction

  function automatic int next_cnt(int st, int cnt, bit c, bit t, bit r, int v);
    if (r || st == 2 || v == 0) return cnt;
    if (c) return v;
    if (st == 1 && t) return cnt - 1;
    return cnt;
  endfunction

  function automatic string pick_tag(int st, bit c, bit r, int v);
    if (r) return "R7";
    if (st == 2) return "R6";
    if (v == 0) return "R2";
    if (st == 0) return "R3";
    if (c) return "R5";
    return "R4";
  endfunction

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s to_flag actual=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input bit c, input bit t, input bit r, input int v, input string tag);
    int ns;
    @(negedge clk);
    char_done = c; bit_tick = t; to_restart = r; to_value = 8'(v);
    @(posedge clk);
    ns    = next_st(m_st, m_cnt, c, t, r, v);
    m_cnt = next_cnt(m_st, m_cnt, c, t, r, v);
    m_st  = ns;
    m_flag = (m_st == 2);
    #1;
    check(to_flag, m_flag, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ws;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check(to_flag, 1'b0, "R1");

    // R3: ticks before any character
    for (int i = 0; i < 10; i++) step(0, 1, 0, 3, "R3");
    // R4: arm and expire after 3 ticks
    step(1, 0, 0, 3, "R4");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 3, "R4");
    // R6: sticky through traffic
    for (int i = 0; i < 4; i++) step(i[0], 1, 0, 3, "R6");
    step(0, 0, 0, 0, "R6");
    // R7: restart with char in same cycle; stays disarmed
    step(1, 0, 1, 3, "R7");
    for (int i = 0; i < 6; i++) step(0, 1, 0, 3, "R7");
    // R5: reload wins over simultaneous tick
    step(1, 0, 0, 3, "R5");
    step(0, 1, 0, 3, "R5");
    step(0, 1, 0, 3, "R5");
    step(1, 1, 0, 3, "R5");
    step(0, 1, 0, 3, "R5");
    step(0, 1, 0, 3, "R5");
    step(0, 1, 0, 3, "R5");
    // R2: zero window, and zero in mid-count
    step(0, 0, 1, 0, "R7");
    step(1, 0, 0, 0, "R2");
    for (int i = 0; i < 300; i++) step(0, 1, 0, 0, "R2");
    step(1, 0, 0, 3, "R2");
    step(0, 1, 0, 3, "R2");
    step(0, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 3, "R2");
    // R8: full-width window
    step(1, 0, 0, 255, "R8");
    for (int i = 0; i < 255; i++) step(0, 1, 0, 255, "R8");
    step(0, 0, 1, 255, "R7");

    // random traffic
    ws = 3;
    for (int i = 0; i < 6000; i++) begin
      bit c, t, r;
      if ($urandom_range(0, 49) == 0)
        ws = ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(1, 5));
      c = ($urandom_range(0, 9) == 0);
      t = ($urandom_range(0, 1) == 0);
      r = ($urandom_range(0, 39) == 0);
      step(c, t, r, ws, pick_tag(m_st, c, r, ws));
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule